// File: doc/BRIEF.md
# Coded-Control Video Byte-Stream Encoder

This block turns a YCrCb 4:2:2 pixel stream with separate timing strobes into one 8-bit bus that carries both the pixel data and the timing events. It runs on a clock at twice the pixel rate. Each pixel occupies two consecutive byte slots: a chroma byte, then a luma byte. Data bytes are saturated so that certain values are never used for data. The encoder uses those free values to signal timing events. An event replaces a whole pixel: the chroma slot carries a marker (0xFF in a Cb pixel, 0xFE in a Cr pixel) and the luma slot carries a small event code.

Inputs are sampled once per pixel, on the rising edge that ends a luma slot. The encoder holds one pixel in a stage register. This lets it look one pixel ahead, so it can announce the start of the active region before that region begins. When several events fall on the same pixel, a fixed precedence chooses one. The events that lose are held and sent on later pixels.

A two-state slot machine alternates between the states PH_CHROMA and PH_LUMA. The transition PH_CHROMA→PH_LUMA happens on every clock. The transition PH_LUMA→PH_CHROMA happens on every clock and is also the pixel sampling point, called the take.

The arbiter names its selection EV_NONE, EV_VRS, EV_HRS, EV_EAV, EV_SAV or EV_INV:
- EV_NONE passes the saturated data through.
- All other selections emit a control pixel.

Top module: `coded_stream_encoder`

## Requirements
- R1: `bs_luma_o` toggles on every clock after reset. `bs_byte_o` carries a chroma byte while `bs_luma_o` is 0 and the luma byte of the same pixel while it is 1.
- R2: Pixel inputs are sampled on each rising edge at which `bs_luma_o` is 1. The pixel sampled at one such edge is decided at the next such edge. Its chroma byte appears right after that edge, and its luma byte follows one clock later.
- R3: A data chroma byte is saturated to 2..253.
- R4: A data luma byte is saturated to 16..253.
- R5: A control pixel's chroma byte is 0xFF when the pixel's `pix_cb_i` was 1 (Cb) and 0xFE when it was 0 (Cr). Its luma byte is the event code.
- R6: A pixel with `frame_rst_i`=1 gives code 0x06 if `next_odd_i`=1 and 0x05 otherwise. A pixel with `line_rst_i`=1 gives code 0x03 if `frame_act_i`=1 and 0x04 otherwise.
- R7: Code 0x01 replaces the first pixel with `line_act_i`=0 that follows a pixel with `line_act_i`=1. Code 0x02 replaces a pixel with `line_act_i`=0 whose next pixel has `line_act_i`=1.
- R8: A pixel with `pix_valid_i`=0 and no other event gives code 0x00. Its marker is 0xFF if the most recent valid pixel was Cb and 0xFE if it was Cr. Before any valid pixel, the marker is 0xFF.
- R9: Precedence runs vertical reset > horizontal reset > end-of-active > start-of-active > invalid. A losing event other than invalid is emitted on the next pixel instead of its data. A losing invalid event is dropped.
- R10: During reset the bus shows 0xFF in a chroma slot. After reset the luma byte is 0x00. Held events are discarded, and the first decided pixel is an invalid pixel 0xFF/0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_y_i | input | 8 | Luma of the incoming pixel |
| pix_c_i | input | 8 | Chroma of the incoming pixel |
| pix_cb_i | input | 1 | 1 = Cb pixel, 0 = Cr pixel |
| pix_valid_i | input | 1 | Pixel carries valid data |
| line_act_i | input | 1 | Pixel lies in the horizontal active region |
| frame_act_i | input | 1 | Line lies in the vertical active region |
| line_rst_i | input | 1 | Horizontal reset on this pixel |
| frame_rst_i | input | 1 | Vertical reset on this pixel |
| next_odd_i | input | 1 | Field after the vertical reset is odd |
| bs_byte_o | output | 8 | Coded byte stream |
| bs_luma_o | output | 1 | 1 while the byte is a luma slot |

## Verification
The interesting overlap is between the event arbiter and the data path on a single pixel. This happens when a vertical and a horizontal reset share a pixel, or when a horizontal reset lands on the pixel just before line activity rises. In each case the winning code goes out first. The deferred code must then replace the next pixel, even a valid active one, with that pixel's own Cb/Cr marker. The table provokes both collisions and compares two consecutive pixels byte by byte. A further directed test leaves an event held across a reset and checks that the data after reset is not replaced.

// File: rtl/cse_pkg.sv
package cse_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] MARK_CB   = 8'hFF;
    localparam logic [BYTE_W-1:0] MARK_CR   = 8'hFE;
    localparam logic [BYTE_W-1:0] CODE_INV  = 8'h00;
    localparam logic [BYTE_W-1:0] CODE_EAV  = 8'h01;
    localparam logic [BYTE_W-1:0] CODE_SAV  = 8'h02;
    localparam logic [BYTE_W-1:0] CODE_HACT = 8'h03;
    localparam logic [BYTE_W-1:0] CODE_HBLK = 8'h04;
    localparam logic [BYTE_W-1:0] CODE_VEVN = 8'h05;
    localparam logic [BYTE_W-1:0] CODE_VODD = 8'h06;

    typedef enum logic {
        PH_CHROMA = 1'b0,
        PH_LUMA   = 1'b1
    } phase_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_VRS,
        EV_HRS,
        EV_EAV,
        EV_SAV,
        EV_INV
    } ev_e;

    typedef struct packed {
        logic [BYTE_W-1:0] y;
        logic [BYTE_W-1:0] c;
        logic              cb;
        logic              valid;
        logic              hact;
        logic              vact;
        logic              hrst;
        logic              vrst;
        logic              odd;
    } pix_t;

endpackage

// File: rtl/cse_phase_fsm.sv
module cse_phase_fsm
    import cse_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic luma_slot_o,
    output logic take_o
);

    phase_e state_q;
    phase_e state_d;

    always_comb begin
        unique case (state_q)
            PH_CHROMA: state_d = PH_LUMA;
            PH_LUMA:   state_d = PH_CHROMA;
            default:   state_d = PH_CHROMA;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_CHROMA;
        else        state_q <= state_d;
    end

    always_comb begin
        luma_slot_o = 1'b0;
        take_o      = 1'b0;
        unique case (state_q)
            PH_CHROMA: begin
                luma_slot_o = 1'b0;
                take_o      = 1'b0;
            end
            PH_LUMA: begin
                luma_slot_o = 1'b1;
                take_o      = 1'b1;
            end
            default: begin
                luma_slot_o = 1'b0;
                take_o      = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cse_clamp.sv
module cse_clamp #(
    parameter int W  = 8,
    parameter int LO = 2,
    parameter int HI = 253
) (
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    always_comb begin
        if (d_i < LO_V)      q_o = LO_V;
        else if (d_i > HI_V) q_o = HI_V;
        else                 q_o = d_i;
    end

endmodule

// File: rtl/cse_event_arb.sv
module cse_event_arb
    import cse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              vrs_i,
    input  logic              odd_i,
    input  logic              hrs_i,
    input  logic              vact_i,
    input  logic              eav_i,
    input  logic              sav_i,
    input  logic              inv_i,
    output ev_e               sel_o,
    output logic [BYTE_W-1:0] code_o
);

    logic pend_vrs_q, pend_odd_q, pend_hrs_q, pend_vact_q, pend_eav_q, pend_sav_q;
    logic req_vrs, req_hrs, req_eav, req_sav;
    logic odd_eff, vact_eff;

    always_comb begin
        req_vrs  = vrs_i | pend_vrs_q;
        req_hrs  = hrs_i | pend_hrs_q;
        req_eav  = eav_i | pend_eav_q;
        req_sav  = sav_i | pend_sav_q;
        odd_eff  = pend_vrs_q ? pend_odd_q  : odd_i;
        vact_eff = pend_hrs_q ? pend_vact_q : vact_i;
    end

    always_comb begin
        if (req_vrs)      sel_o = EV_VRS;
        else if (req_hrs) sel_o = EV_HRS;
        else if (req_eav) sel_o = EV_EAV;
        else if (req_sav) sel_o = EV_SAV;
        else if (inv_i)   sel_o = EV_INV;
        else              sel_o = EV_NONE;
    end

    always_comb begin
        unique case (sel_o)
            EV_VRS:  code_o = odd_eff  ? CODE_VODD : CODE_VEVN;
            EV_HRS:  code_o = vact_eff ? CODE_HACT : CODE_HBLK;
            EV_EAV:  code_o = CODE_EAV;
            EV_SAV:  code_o = CODE_SAV;
            EV_INV:  code_o = CODE_INV;
            default: code_o = CODE_INV;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_vrs_q  <= 1'b0;
            pend_odd_q  <= 1'b0;
            pend_hrs_q  <= 1'b0;
            pend_vact_q <= 1'b0;
            pend_eav_q  <= 1'b0;
            pend_sav_q  <= 1'b0;
        end else if (take_i) begin
            pend_vrs_q  <= req_vrs && (sel_o != EV_VRS);
            pend_odd_q  <= odd_eff;
            pend_hrs_q  <= req_hrs && (sel_o != EV_HRS);
            pend_vact_q <= vact_eff;
            pend_eav_q  <= req_eav && (sel_o != EV_EAV);
            pend_sav_q  <= req_sav && (sel_o != EV_SAV);
        end
    end

endmodule

// File: rtl/coded_stream_encoder.sv
module coded_stream_encoder
    import cse_pkg::*;
#(
    parameter int C_LO = 2,
    parameter int C_HI = 253,
    parameter int Y_LO = 16,
    parameter int Y_HI = 253
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] pix_y_i,
    input  logic [BYTE_W-1:0] pix_c_i,
    input  logic              pix_cb_i,
    input  logic              pix_valid_i,
    input  logic              line_act_i,
    input  logic              frame_act_i,
    input  logic              line_rst_i,
    input  logic              frame_rst_i,
    input  logic              next_odd_i,
    output logic [BYTE_W-1:0] bs_byte_o,
    output logic              bs_luma_o
);

    localparam int NCOMP = 2;
    localparam int LOS [NCOMP] = '{C_LO, Y_LO};
    localparam int HIS [NCOMP] = '{C_HI, Y_HI};

    logic              luma_slot, take;
    pix_t              live, stage_q;
    logic              hact_prev_q, last_cb_q;
    logic [BYTE_W-1:0] out_c_q, out_l_q;
    logic [BYTE_W-1:0] raw   [NCOMP];
    logic [BYTE_W-1:0] sat   [NCOMP];
    ev_e               sel;
    logic [BYTE_W-1:0] code, marker;
    logic              eav_new, sav_new;

    always_comb begin
        live.y     = pix_y_i;
        live.c     = pix_c_i;
        live.cb    = pix_cb_i;
        live.valid = pix_valid_i;
        live.hact  = line_act_i;
        live.vact  = frame_act_i;
        live.hrst  = line_rst_i;
        live.vrst  = frame_rst_i;
        live.odd   = next_odd_i;
    end

    cse_phase_fsm i_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .luma_slot_o (luma_slot),
        .take_o      (take)
    );

    assign raw[0] = stage_q.c;
    assign raw[1] = stage_q.y;

    for (genvar g = 0; g < NCOMP; g++) begin : g_sat
        cse_clamp #(.W(BYTE_W), .LO(LOS[g]), .HI(HIS[g])) i_clamp (
            .d_i (raw[g]),
            .q_o (sat[g])
        );
    end

    always_comb begin
        eav_new = hact_prev_q && !stage_q.hact;
        sav_new = live.hact && !stage_q.hact;
    end

    cse_event_arb i_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .vrs_i  (stage_q.vrst),
        .odd_i  (stage_q.odd),
        .hrs_i  (stage_q.hrst),
        .vact_i (stage_q.vact),
        .eav_i  (eav_new),
        .sav_i  (sav_new),
        .inv_i  (!stage_q.valid),
        .sel_o  (sel),
        .code_o (code)
    );

    always_comb begin
        if (sel == EV_INV) marker = last_cb_q    ? MARK_CB : MARK_CR;
        else               marker = stage_q.cb   ? MARK_CB : MARK_CR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q     <= '0;
            hact_prev_q <= 1'b0;
            last_cb_q   <= 1'b1;
            out_c_q     <= MARK_CB;
            out_l_q     <= CODE_INV;
        end else if (take) begin
            stage_q     <= live;
            hact_prev_q <= stage_q.hact;
            if (stage_q.valid) last_cb_q <= stage_q.cb;
            if (sel == EV_NONE) begin
                out_c_q <= sat[0];
                out_l_q <= sat[1];
            end else begin
                out_c_q <= marker;
                out_l_q <= code;
            end
        end
    end

    always_comb begin
        bs_luma_o = luma_slot;
        bs_byte_o = luma_slot ? out_l_q : out_c_q;
    end

endmodule

// File: rtl/cse_checker.sv
module cse_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bs_byte_o,
    input logic       bs_luma_o
);

    // R1
    slot_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bs_luma_o != $past(bs_luma_o)));

    // R3
    chroma_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bs_luma_o |-> (bs_byte_o >= 8'd2));

    // R5
    marker_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bs_luma_o && bs_byte_o >= 8'hFE) |=> (bs_byte_o <= 8'h06));

    // R4
    data_luma_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bs_luma_o && bs_byte_o < 8'hFE) |=> (bs_byte_o >= 8'd16 && bs_byte_o <= 8'd253));

endmodule

bind coded_stream_encoder cse_checker i_cse_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bs_byte_o (bs_byte_o),
    .bs_luma_o (bs_luma_o)
);

// File: tb/test_coded_stream_encoder.sv
module test_coded_stream_encoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pix_y = '0, pix_c = '0;
    logic       pix_cb = 1'b0, pix_valid = 1'b0, line_act = 1'b0, frame_act = 1'b0;
    logic       line_rst = 1'b0, frame_rst = 1'b0, next_odd = 1'b0;
    logic [7:0] bs_byte;
    logic       bs_luma;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    coded_stream_encoder i_coded_stream_encoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_y_i     (pix_y),
        .pix_c_i     (pix_c),
        .pix_cb_i    (pix_cb),
        .pix_valid_i (pix_valid),
        .line_act_i  (line_act),
        .frame_act_i (frame_act),
        .line_rst_i  (line_rst),
        .frame_rst_i (frame_rst),
        .next_odd_i  (next_odd),
        .bs_byte_o   (bs_byte),
        .bs_luma_o   (bs_luma)
    );

    // row: y, c, cb, valid, hact, vact, hrst, vrst, odd, expected chroma/luma of the PREVIOUS pixel
    localparam int NROW = 22;
    localparam logic [38:0] TBL [NROW] = '{
        {8'h10, 8'h80, 7'b1101100, 8'hFF, 8'h00},
        {8'h20, 8'h80, 7'b0101000, 8'hFF, 8'h03},
        {8'h05, 8'h01, 7'b1101000, 8'h80, 8'h20},
        {8'h05, 8'h01, 7'b0111000, 8'hFF, 8'h02},
        {8'hFF, 8'hFF, 7'b1111000, 8'h02, 8'h10},
        {8'h00, 8'h00, 7'b0011000, 8'hFD, 8'hFD},
        {8'h80, 8'hFE, 7'b1111000, 8'hFF, 8'h00},
        {8'h40, 8'h30, 7'b0111000, 8'hFD, 8'h80},
        {8'h10, 8'h80, 7'b1101000, 8'h30, 8'h40},
        {8'h10, 8'h80, 7'b0100111, 8'hFF, 8'h01},
        {8'h10, 8'h80, 7'b1100000, 8'hFE, 8'h06},
        {8'h30, 8'h90, 7'b0100010, 8'hFF, 8'h04},
        {8'h10, 8'h80, 7'b1101100, 8'hFE, 8'h05},
        {8'h50, 8'h60, 7'b0111000, 8'hFF, 8'h03},
        {8'hEB, 8'h10, 7'b1111000, 8'hFE, 8'h02},
        {8'h00, 8'h00, 7'b0011000, 8'h10, 8'hEB},
        {8'h11, 8'h22, 7'b1111000, 8'hFF, 8'h00},
        {8'h12, 8'h23, 7'b0111000, 8'h22, 8'h11},
        {8'h00, 8'h00, 7'b1011000, 8'h23, 8'h12},
        {8'h10, 8'h80, 7'b1101000, 8'hFE, 8'h00},
        {8'h20, 8'h80, 7'b0101000, 8'hFF, 8'h01},
        {8'h10, 8'h80, 7'b1101000, 8'h80, 8'h20}
    };

    function automatic string tag_of(int k);
        case (k)
            0:       return "R10";
            1, 12:   return "R6";
            3, 9:    return "R7";
            20:      return "R7";
            4, 7:    return "R3";
            5:       return "R4";
            6, 16:   return "R8";
            19:      return "R8";
            8, 15:   return "R2";
            18:      return "R2";
            10, 11:  return "R9";
            14:      return "R9";
            13:      return "R5";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [38:0] r);
        pix_y     = r[38:31];
        pix_c     = r[30:23];
        pix_cb    = r[22];
        pix_valid = r[21];
        line_act  = r[20];
        frame_act = r[19];
        line_rst  = r[18];
        frame_rst = r[17];
        next_odd  = r[16];
    endtask

    // called at a negedge inside a luma slot
    task automatic px(logic [38:0] r, string tag);
        drive(r);
        @(negedge clk);
        chk({tag, " chroma"}, bs_byte, r[15:8]);
        chk("R1 slot", {7'd0, bs_luma}, 8'd0);
        @(negedge clk);
        chk({tag, " luma"}, bs_byte, r[7:0]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 reset chroma", bs_byte, 8'hFF);
        chk("R10 reset slot", {7'd0, bs_luma}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 post-reset luma", bs_byte, 8'h00);
        chk("R1 post-reset slot", {7'd0, bs_luma}, 8'd1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        for (int k = 0; k < NROW; k++) px(TBL[k], tag_of(k));

        // R9 held event is discarded by reset (R10)
        px({8'h10, 8'h80, 7'b1101110, 8'h80, 8'h10}, "R9 collide");
        px({8'h10, 8'h80, 7'b0101000, 8'hFF, 8'h05}, "R9 vreset wins");
        @(negedge clk);
        do_reset();
        px({8'h40, 8'h70, 7'b1101000, 8'hFF, 8'h00}, "R10 first pixel");
        px({8'h41, 8'h71, 7'b0101000, 8'h70, 8'h40}, "R10 held dropped");
        px({8'h10, 8'h80, 7'b1101000, 8'h71, 8'h41}, "R2 data");
        finish_run();
    end

endmodule